// File: doc/BRIEF.md
# SPI Master FIFO Register Front-End

This block sits between a 32-bit register bus and the shift engine of an SPI master. It holds a transmit queue and a receive queue of 16-bit data items. A full-word write to the transmit data register queues two items, the low halfword first. A halfword write queues one item. Each read of the receive data register returns and removes one item. Software watches the queues through a fill-level register and through a status register. That register combines live empty and full bits with sticky flags for thresholds, pointer errors and overrun, and an enable mask gates the sticky and live bits onto one interrupt line.

Queue mode is switched by command bits in a control register. While it is on, each queue holds up to `DEPTH` items. While it is off, each queue is a single holding register. Further command bits empty either queue. The shift engine is a loopback model. While the transmit queue holds data, it moves one item every `SHIFT_CYCLES` clocks into the receive queue. If the receive queue is full, the item is dropped and overrun is recorded.

Register offsets (byte addresses): control 0x00 (write only, reads as zero), status 0x04, interrupt enable 0x08, mode 0x0C, level 0x10, transmit data 0x14 (write only), receive data 0x18 (read only). A read returns its data on `busRdData` one clock after `busRdEn`.

Top module: `spi_fifo_front`

## Requirements
- R1: A write to transmit data with byte enables 4'b1111 queues bits 15:0 and then bits 31:16 as two items. Byte enables 4'b0011 queue bits 15:0 as one item. Any other byte-enable pattern leaves both queues unchanged.
- R2: A read of receive data returns the oldest item in bits 15:0 with bits 31:16 zero, and removes exactly that one item. A read while the queue is empty returns zero and sets the receive pointer-error flag (status bit 31).
- R3: The level register reports the transmit fill count in bits 5:0 and the receive fill count in bits 21:16. All other bits are zero.
- R4: A halfword write is dropped when the transmit queue is full. A word write is dropped whole, with nothing queued, when fewer than two entries are free. Both cases set the transmit pointer-error flag (status bit 30).
- R5: While the transmit queue is not empty, the loopback engine moves one item to the receive queue every SHIFT_CYCLES clocks. When the receive queue is full, the item is discarded and the overrun flag (status bit 3) is set.
- R6: Status bits 24, 25, 27 and 28 are live: transmit empty, transmit full, receive empty and receive full. The sticky flags are bit 26 (set while transmit count is at or below the transmit threshold), bit 29 (set while receive count is at or above the receive threshold), and bits 30, 31 and 3. A status read returns the flags and then clears them, and a set in the same clock wins.
- R7: The mode register stores the transmit threshold in bits 21:16, the receive threshold in bits 29:24, and two 2-bit ready-mode fields in bits 1:0 and 5:4. It reads back exactly those bits.
- R8: Control bit 16 empties the transmit queue and control bit 17 empties the receive queue. A flush overrides a push in the same clock.
- R9: Control bit 30 turns queue mode on (DEPTH entries) and bit 31 turns it off, with bit 31 winning if both are set. Either command empties both queues. When queue mode is off, each queue holds one item. Queue mode is off after reset.
- R10: `irq` is high exactly when some status bit is set and its bit in the interrupt enable register (offset 0x08, same bit positions) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busByteEn | input | 4 | Byte enables of the write |
| busRdData | output | 32 | Read data, valid one clock after busRdEn |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the edges of the write decode. A word write that arrives with only one free entry must vanish whole. A design that queued only the low half would leave a stray item, which shows in the level register. An odd byte-enable pattern must queue nothing. A read of an empty receive queue must return zero and flag an error, and a faulty pointer would instead return stale data. Overrun is provoked by filling the receive queue past its depth. A scoreboard proves that the first DEPTH items survive in order and the late ones are lost. The bench also covers flushes and mode switches with data in flight, the clear-on-read behaviour of the status flags, and the single-entry capacity with queue mode off.

// File: rtl/spi_ff_pkg.sv
package spi_ff_pkg;
  localparam int DataW = 16;

  localparam logic [7:0] AddrCtrl  = 8'h00;
  localparam logic [7:0] AddrStat  = 8'h04;
  localparam logic [7:0] AddrIen   = 8'h08;
  localparam logic [7:0] AddrMode  = 8'h0C;
  localparam logic [7:0] AddrLevel = 8'h10;
  localparam logic [7:0] AddrTxd   = 8'h14;
  localparam logic [7:0] AddrRxd   = 8'h18;

  localparam int CmdTxFlush = 16;
  localparam int CmdRxFlush = 17;
  localparam int CmdOn      = 30;
  localparam int CmdOff     = 31;

  localparam int StOvr    = 3;
  localparam int StTxEmp  = 24;
  localparam int StTxFull = 25;
  localparam int StTxThr  = 26;
  localparam int StRxEmp  = 27;
  localparam int StRxFull = 28;
  localparam int StRxThr  = 29;
  localparam int StTxErr  = 30;
  localparam int StRxErr  = 31;

  typedef struct packed {
    logic             txPush1;
    logic             txPush2;
    logic [DataW-1:0] txD0;
    logic [DataW-1:0] txD1;
    logic             rxPop;
    logic             txFlush;
    logic             rxFlush;
    logic             capOne;
  } strobe_t;
endpackage

// File: rtl/spi_ff_fifo.sv
module spi_ff_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push1,
  input  logic          push2,
  input  logic [DW-1:0] d0,
  input  logic [DW-1:0] d1,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] incPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] wrPtr1;
  logic [CW-1:0] addN;
  assign wrPtr1 = incPtr(wrPtr);
  assign addN   = push2 ? CW'(2) : (push1 ? CW'(1) : CW'(0));
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!flush && (push1 || push2)) mem[wrPtr] <= d0;
    if (!flush && push2) mem[wrPtr1] <= d1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push2)      wrPtr <= incPtr(wrPtr1);
      else if (push1) wrPtr <= wrPtr1;
      if (pop) rdPtr <= incPtr(rdPtr);
      count <= count + addN - (pop ? CW'(1) : CW'(0));
    end
  end

  // R4: no push may land on a full queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (push2 && !flush) |-> (count <= CW'(DEPTH - 2)));
  p_no_overflow1_r4: assert property (@(posedge clk) disable iff (!rstN)
    (push1 && !flush) |-> (count < CW'(DEPTH)));
  // R2: no pop from an empty queue
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/spi_ff_datapath.sv
module spi_ff_datapath
  import spi_ff_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int SHIFT_CYCLES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = (SHIFT_CYCLES > 1) ? $clog2(SHIFT_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [CW-1:0]    txCount,
  output logic [CW-1:0]    rxCount,
  output logic [DataW-1:0] rxHead,
  output logic             ovrEvt
);
  logic [SW-1:0]    shiftCnt;
  logic [DataW-1:0] txHead;
  logic [CW-1:0]    capV;
  logic             fire, rxRoom, rxPush, txPop;

  assign capV   = stb.capOne ? CW'(1) : CW'(DEPTH);
  assign fire   = (txCount != '0) && (shiftCnt == SW'(SHIFT_CYCLES - 1));
  assign rxRoom = rxCount < capV;
  assign txPop  = fire && !stb.txFlush;
  assign rxPush = fire && rxRoom && !stb.rxFlush;
  assign ovrEvt = fire && !rxRoom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftCnt <= '0;
    else if (txCount == '0 || fire || stb.txFlush) shiftCnt <= '0;
    else shiftCnt <= shiftCnt + 1'b1;
  end

  spi_ff_fifo #(.DEPTH(DEPTH), .DW(DataW)) uTxQ (
    .clk(clk), .rstN(rstN), .flush(stb.txFlush),
    .push1(stb.txPush1), .push2(stb.txPush2),
    .d0(stb.txD0), .d1(stb.txD1), .pop(txPop),
    .head(txHead), .count(txCount)
  );

  spi_ff_fifo #(.DEPTH(DEPTH), .DW(DataW)) uRxQ (
    .clk(clk), .rstN(rstN), .flush(stb.rxFlush),
    .push1(rxPush), .push2(1'b0),
    .d0(txHead), .d1('0), .pop(stb.rxPop),
    .head(rxHead), .count(rxCount)
  );

  // R5: an overrun leaves the receive queue as it was
  p_overrun_keeps_rx_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovrEvt && !stb.rxPop && !stb.rxFlush) |=> (rxCount == $past(rxCount)));
  // R5: a transfer moves one item out of the transmit queue
  p_engine_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !stb.txFlush && !stb.txPush1 && !stb.txPush2) |=>
      (txCount == $past(txCount) - CW'(1)));
endmodule

// File: rtl/spi_ff_ctrl.sv
module spi_ff_ctrl
  import spi_ff_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWrData,
  input  logic [3:0]       busByteEn,
  input  logic [CW-1:0]    txCount,
  input  logic [CW-1:0]    rxCount,
  input  logic [DataW-1:0] rxHead,
  input  logic             ovrEvt,
  output strobe_t          stb,
  output logic [31:0]      busRdData,
  output logic             irq
);
  logic        fifoEn;
  logic [31:0] ienReg;
  logic [5:0]  txThr, rxThr;
  logic [1:0]  txRdyMode, rxRdyMode;
  logic        txThrF, rxThrF, txErrF, rxErrF, ovrF;

  logic [CW-1:0] capV, txFree;
  logic ctrlWr, modeCmd, wrTx, isWord, isHalf, rdRx, statRd;
  logic txFlush, rxFlush, txErr, rxErr, txThrSet, rxThrSet;
  logic [31:0] statusWord;

  assign capV    = fifoEn ? CW'(DEPTH) : CW'(1);
  assign txFree  = capV - txCount;
  assign ctrlWr  = busWrEn && (busAddr == AddrCtrl);
  assign modeCmd = ctrlWr && (busWrData[CmdOn] || busWrData[CmdOff]);
  assign txFlush = (ctrlWr && busWrData[CmdTxFlush]) || modeCmd;
  assign rxFlush = (ctrlWr && busWrData[CmdRxFlush]) || modeCmd;
  assign wrTx    = busWrEn && (busAddr == AddrTxd);
  assign isWord  = busByteEn == 4'b1111;
  assign isHalf  = busByteEn == 4'b0011;
  assign rdRx    = busRdEn && (busAddr == AddrRxd);
  assign statRd  = busRdEn && (busAddr == AddrStat);

  assign txErr = wrTx && !txFlush &&
                 ((isWord && txFree < CW'(2)) || (isHalf && txFree == '0));
  assign rxErr = rdRx && (rxCount == '0);

  assign txThrSet = 7'(txCount) <= {1'b0, txThr};
  assign rxThrSet = 7'(rxCount) >= {1'b0, rxThr};

  always_comb begin
    stb         = '0;
    stb.txD0    = busWrData[15:0];
    stb.txD1    = busWrData[31:16];
    stb.txPush2 = wrTx && isWord && (txFree >= CW'(2)) && !txFlush;
    stb.txPush1 = wrTx && isHalf && (txFree != '0) && !txFlush;
    stb.rxPop   = rdRx && (rxCount != '0) && !rxFlush;
    stb.txFlush = txFlush;
    stb.rxFlush = rxFlush;
    stb.capOne  = !fifoEn;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[StOvr]    = ovrF;
    statusWord[StTxEmp]  = txCount == '0;
    statusWord[StTxFull] = txCount == capV;
    statusWord[StTxThr]  = txThrF;
    statusWord[StRxEmp]  = rxCount == '0;
    statusWord[StRxFull] = rxCount == capV;
    statusWord[StRxThr]  = rxThrF;
    statusWord[StTxErr]  = txErrF;
    statusWord[StRxErr]  = rxErrF;
  end

  assign irq = |(statusWord & ienReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn    <= 1'b0;
      ienReg    <= '0;
      txThr     <= '0;
      rxThr     <= '0;
      txRdyMode <= '0;
      rxRdyMode <= '0;
      txThrF    <= 1'b0;
      rxThrF    <= 1'b0;
      txErrF    <= 1'b0;
      rxErrF    <= 1'b0;
      ovrF      <= 1'b0;
      busRdData <= '0;
    end else begin
      if (ctrlWr) begin
        if (busWrData[CmdOff])     fifoEn <= 1'b0;
        else if (busWrData[CmdOn]) fifoEn <= 1'b1;
      end
      if (busWrEn && busAddr == AddrIen) ienReg <= busWrData;
      if (busWrEn && busAddr == AddrMode) begin
        txRdyMode <= busWrData[1:0];
        rxRdyMode <= busWrData[5:4];
        txThr     <= busWrData[21:16];
        rxThr     <= busWrData[29:24];
      end
      txThrF <= (txThrF && !statRd) || txThrSet;
      rxThrF <= (rxThrF && !statRd) || rxThrSet;
      txErrF <= (txErrF && !statRd) || txErr;
      rxErrF <= (rxErrF && !statRd) || rxErr;
      ovrF   <= (ovrF   && !statRd) || ovrEvt;
      if (busRdEn) begin
        unique case (busAddr)
          AddrStat:  busRdData <= statusWord;
          AddrIen:   busRdData <= ienReg;
          AddrMode:  busRdData <= {2'b0, rxThr, 2'b0, txThr, 10'b0,
                                   rxRdyMode, 2'b0, txRdyMode};
          AddrLevel: busRdData <= {10'b0, 6'(rxCount), 10'b0, 6'(txCount)};
          AddrRxd:   busRdData <= (rxCount != '0) ? {16'b0, rxHead} : 32'b0;
          default:   busRdData <= '0;
        endcase
      end
    end
  end

  // R2: an empty read raises the receive pointer error
  p_rx_err_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxCount == '0) |=> rxErrF);
  // R8: a flush leaves the queue empty
  p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txCount == '0));
  p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |=> (rxCount == '0));
  // R9: single-entry capacity while queue mode is off
  p_cap_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> (txCount <= CW'(1) && rxCount <= CW'(1)));
  // R1: an accepted word write grows the transmit queue
  p_word_push_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPush2 |=> (txCount >= $past(txCount) + CW'(1)));
endmodule

// File: rtl/spi_fifo_front.sv
module spi_fifo_front
  import spi_ff_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int SHIFT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWrData,
  input  logic [3:0]  busByteEn,
  output logic [31:0] busRdData,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  strobe_t          stb;
  logic [CW-1:0]    txCount, rxCount;
  logic [DataW-1:0] rxHead;
  logic             ovrEvt;

  spi_ff_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busByteEn(busByteEn),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .ovrEvt(ovrEvt),
    .stb(stb), .busRdData(busRdData), .irq(irq)
  );

  spi_ff_datapath #(.DEPTH(DEPTH), .SHIFT_CYCLES(SHIFT_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .ovrEvt(ovrEvt)
  );
endmodule

// File: tb/sim_spi_fifo_front.sv
`timescale 1ns/1ps
module sim_spi_fifo_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busRdData;
  logic        irq;

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] expQ[$];
  logic [31:0] v;

  always #2 clk = ~clk;

  spi_fifo_front #(.DEPTH(16), .SHIFT_CYCLES(4)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busByteEn(busByteEn),
    .busRdData(busRdData), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<50000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue expected items as they are written
  task automatic pushWord(input logic [31:0] d);
    wr(8'h14, d, 4'hF);
    expQ.push_back(d[15:0]);
    expQ.push_back(d[31:16]);
  endtask

  task automatic pushHalf(input logic [15:0] d);
    wr(8'h14, {16'hDEAD, d}, 4'h3);
    expQ.push_back(d);
  endtask

  // monitor: pop each result and compare with the oldest expected item
  task automatic drain(input int n, input string tag);
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      rd(8'h18, r);
      if (expQ.size() == 0) chk({tag, " scoreboard empty"}, 32'd1, 32'd0);
      else chk(tag, r, {16'h0, expQ.pop_front()});
    end
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(3);

    // reset state
    rd(8'h04, v); chk("R6 reset status", v, 32'h2D00_0000);
    rd(8'h10, v); chk("R3 reset level", v, 32'h0);
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R9 control reads zero", v, 32'h0);

    // mode register layout
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h0C, v); chk("R7 mode readback mask", v, 32'h3F3F_0033);
    wr(8'h0C, 32'h2A15_0031, 4'hF);
    rd(8'h0C, v); chk("R7 mode readback", v, 32'h2A15_0031);
    wr(8'h0C, 32'h3F00_0000, 4'hF);

    // queue mode on, word plus halfword
    wr(8'h00, 32'h4000_0000, 4'hF);
    pushWord(32'hBBBB_AAAA);
    pushHalf(16'h1234);
    idle(40);
    rd(8'h10, v); chk("R5 R3 level after loopback", v, 32'h0003_0000);
    drain(3, "R1 R2 order");
    rd(8'h18, v); chk("R2 empty read data", v, 32'h0);
    rd(8'h04, v); chk("R2 rx pointer error", v & 32'h8000_0000, 32'h8000_0000);
    rd(8'h04, v); chk("R6 status read clears", v & 32'h8000_0000, 32'h0);

    // odd byte enables ignored
    wr(8'h14, 32'h5555_5555, 4'h1);
    wr(8'h14, 32'h5555_5555, 4'hC);
    idle(20);
    rd(8'h10, v); chk("R1 odd byte enables ignored", v, 32'h0);

    // receive threshold and interrupt
    wr(8'h0C, 32'h0200_0000, 4'hF);
    rd(8'h04, v);
    wr(8'h08, 32'h2000_0000, 4'hF);
    idle(1);
    chk("R10 irq low below threshold", {31'b0, irq}, 32'h0);
    pushHalf(16'h0101);
    pushHalf(16'h0202);
    idle(30);
    chk("R10 irq on rx threshold", {31'b0, irq}, 32'h1);
    rd(8'h04, v); chk("R6 rx threshold flag", v & 32'h2000_0000, 32'h2000_0000);
    drain(2, "R2 threshold items");
    rd(8'h04, v);
    rd(8'h04, v); chk("R6 rx threshold cleared", v & 32'h2000_0000, 32'h0);
    wr(8'h08, 32'h0, 4'hF);
    wr(8'h0C, 32'h3F00_0000, 4'hF);

    // overrun of the receive queue
    for (int i = 0; i < 9; i++) begin
      pushWord({16'(2 * i + 16'h101), 16'(2 * i + 16'h100)});
      idle(10);
    end
    idle(40);
    rd(8'h10, v); chk("R5 rx full level", v, 32'h0010_0000);
    rd(8'h04, v); chk("R5 overrun and full", v & 32'h1000_0008, 32'h1000_0008);
    drain(16, "R5 surviving items");
    chk("R5 lost item count", expQ.size(), 32'd2);
    expQ.delete();
    rd(8'h04, v);

    // mode off flushes and limits capacity
    pushHalf(16'h7777);
    idle(20);
    wr(8'h00, 32'hC000_0000, 4'hF);
    rd(8'h10, v); chk("R9 mode change flushes", v, 32'h0);
    expQ.delete();
    rd(8'h04, v);
    wr(8'h14, 32'h9999_8888, 4'hF);
    rd(8'h10, v); chk("R4 word dropped whole", v, 32'h0);
    rd(8'h04, v); chk("R4 tx pointer error word", v & 32'h4000_0000, 32'h4000_0000);
    pushHalf(16'h4444);
    wr(8'h14, 32'h0000_5555, 4'h3);
    rd(8'h04, v); chk("R4 tx pointer error full", v & 32'h4000_0000, 32'h4000_0000);
    idle(20);
    rd(8'h10, v); chk("R9 depth one level", v, 32'h0001_0000);
    pushHalf(16'h6666);
    idle(20);
    rd(8'h04, v); chk("R9 R5 overrun at depth one", v & 32'h1000_0008, 32'h1000_0008);
    drain(1, "R9 held item");
    expQ.delete();

    // flush commands
    wr(8'h14, 32'h0000_AAAA, 4'h3);
    wr(8'h00, 32'h0001_0000, 4'hF);
    rd(8'h10, v); chk("R8 tx flush", v, 32'h0);
    idle(20);
    rd(8'h10, v); chk("R8 flushed item never sent", v, 32'h0);
    wr(8'h14, 32'h0000_BBBB, 4'h3);
    idle(20);
    wr(8'h00, 32'h0002_0000, 4'hF);
    rd(8'h10, v); chk("R8 rx flush", v, 32'h0);

    // enable command while on also flushes
    wr(8'h00, 32'h4000_0000, 4'hF);
    pushWord(32'h2222_1111);
    idle(20);
    wr(8'h00, 32'h4000_0000, 4'hF);
    rd(8'h10, v); chk("R9 enable command flushes", v, 32'h0);
    expQ.delete();
    pushWord(32'h3333_CCCC);
    idle(20);
    drain(2, "R1 after re-enable");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule